// File: doc/BRIEF.md
# Expected-Response Fault Diagnosis Unit

This block sits at the observation end of a memory test. Each clock it receives one serial response bit from the memory under test, together with the memory address that bit belongs to. It looks up the bit that a healthy memory would have produced in a stored response sequence and compares the two. On a mismatch it reports a fault, names the kind of stuck-at fault, and shows the memory address that failed.

The stored sequence is a parameter. A pointer into it starts at entry zero after reset and advances by one on every clock, on the same clock as the test, so the stimulus generator and this unit stay in lockstep without any handshake. Diagnosis outputs are registered and last one cycle per mismatch. A sticky flag records that at least one fault was seen, so a whole run can be judged once it ends. When no fault is flagged, the address output is either driven to zero with a low valid flag, or released to high impedance; a parameter selects which.

Top module: `fdiag_top`

## Requirements
- R1: The expected bit for the k-th clock after reset is released (k counting from 0) is bit (k mod DEPTH) of the parameter EXP_BITS, bit 0 first.
- R2: `faulty` is high in the cycle after an edge exactly when, at that edge, `obs_bit` differed from the expected bit; each mismatch gives a one-cycle pulse.
- R3: `sa0` is raised when the expected bit is 1 and `obs_bit` is 0; `sa1` when the expected bit is 0 and `obs_bit` is 1. At most one of them is high, and `faulty` equals their OR.
- R4: While `faulty` is high, `fault_addr` shows the `test_addr` value sampled with the mismatch and `addr_valid` is high. Otherwise `addr_valid` is low and `fault_addr` is 0 (or high impedance when TRISTATE_OUT is 1).
- R5: `any_fault` goes high with the first mismatch and stays high, through matching cycles, until reset.
- R6: A synchronous, active-high `rst` clears the pointer to entry 0 and drives every output flag and `fault_addr` low in the cycle after the edge.
- R7: After entry DEPTH-1 the pointer returns to entry 0, so the sequence repeats for runs longer than DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock, shared with the memory under test |
| rst | input | 1 | Synchronous reset, active high |
| obs_bit | input | 1 | Observed response bit from the memory under test |
| test_addr | input | ADDR_W | Memory address the observed bit belongs to |
| faulty | output | 1 | Registered mismatch pulse |
| sa0 | output | 1 | Mismatch classified as stuck-at-0 |
| sa1 | output | 1 | Mismatch classified as stuck-at-1 |
| fault_addr | output | ADDR_W | Failing memory address while `faulty` is high |
| addr_valid | output | 1 | High when `fault_addr` carries an address |
| any_fault | output | 1 | Sticky record of any mismatch since reset |

## Verification
The hardest situation to reach from the ports is a mismatch at a chosen position of the stored sequence after the pointer has wrapped, because the position is never visible and only the count of clocks since reset fixes it. The bench keeps its own position count from the reset release, runs well past DEPTH cycles with mostly matching random responses, and injects deliberate mismatches so that both fault kinds land on entries after the wrap. A reset mid-run then checks that the count, the flags and the sticky record all start over.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_SA0  = 2'd1,
        FK_SA1  = 2'd2
    } fault_kind_e;

endpackage

// File: rtl/fdiag_rom.sv
module fdiag_rom #(
    parameter int                DEPTH    = 24,
    parameter logic [DEPTH-1:0]  EXP_BITS = '0,
    localparam int               PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [PTR_W-1:0] ptr,
    output logic             exp_bit
);
    // Fixed response sequence, entry 0 first.
    always_comb begin
        exp_bit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr == PTR_W'(i)) exp_bit = EXP_BITS[i];
        end
    end
endmodule

// File: rtl/fdiag_classify.sv
module fdiag_classify
    import fdiag_pkg::*;
(
    input  logic        obs_bit,
    input  logic        exp_bit,
    output fault_kind_e kind
);
    always_comb begin
        if (obs_bit == exp_bit) kind = FK_NONE;
        else if (exp_bit)       kind = FK_SA0;
        else                    kind = FK_SA1;
    end
endmodule

// File: rtl/fdiag_addr_drv.sv
module fdiag_addr_drv #(
    parameter int ADDR_W       = 4,
    parameter bit TRISTATE_OUT = 1'b0
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    generate
        if (TRISTATE_OUT) begin : g_hiz
            assign addr_out = valid ? addr_in : {ADDR_W{1'bz}};
        end else begin : g_zero
            assign addr_out = valid ? addr_in : '0;
        end
    endgenerate
endmodule

// File: rtl/fdiag_top.sv
module fdiag_top
    import fdiag_pkg::*;
#(
    parameter int               DEPTH        = 24,
    parameter logic [DEPTH-1:0] EXP_BITS     = 24'hA53C0F,
    parameter int               ADDR_W       = 4,
    parameter bit               TRISTATE_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              obs_bit,
    input  logic [ADDR_W-1:0] test_addr,
    output logic              faulty,
    output logic              sa0,
    output logic              sa1,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              addr_valid,
    output logic              any_fault
);
    localparam int               PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              faulty;
        logic              sa0;
        logic              sa1;
        logic              any;
        logic [ADDR_W-1:0] addr;
    } st_t;

    st_t         st_d, st_q;
    logic        exp_bit;
    fault_kind_e kind;

    fdiag_rom #(
        .DEPTH    (DEPTH),
        .EXP_BITS (EXP_BITS)
    ) u_rom (
        .ptr     (st_q.ptr),
        .exp_bit (exp_bit)
    );

    fdiag_classify u_cls (
        .obs_bit (obs_bit),
        .exp_bit (exp_bit),
        .kind    (kind)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.ptr    = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
            st_d.faulty = (kind != FK_NONE);
            st_d.sa0    = (kind == FK_SA0);
            st_d.sa1    = (kind == FK_SA1);
            st_d.addr   = (kind != FK_NONE) ? test_addr : '0;
            st_d.any    = st_q.any | (kind != FK_NONE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    fdiag_addr_drv #(
        .ADDR_W       (ADDR_W),
        .TRISTATE_OUT (TRISTATE_OUT)
    ) u_drv (
        .valid    (st_q.faulty),
        .addr_in  (st_q.addr),
        .addr_out (fault_addr)
    );

    assign faulty     = st_q.faulty;
    assign sa0        = st_q.sa0;
    assign sa1        = st_q.sa1;
    assign addr_valid = st_q.faulty;
    assign any_fault  = st_q.any;
endmodule

// File: rtl/fdiag_chk.sv
module fdiag_chk #(
    parameter int DEPTH = 24,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             faulty,
    input logic             sa0,
    input logic             sa1,
    input logic             addr_valid,
    input logic             any_fault,
    input logic [PTR_W-1:0] ptr
);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sa0, sa1}) && (faulty == (sa0 | sa1)));

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        addr_valid == faulty);

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(any_fault) && !$past(rst) |-> any_fault);

    a_r5_raise: assert property (@(posedge clk) disable iff (rst)
        faulty |-> any_fault);

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !faulty && !any_fault && ptr == '0);

    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(ptr) == PTR_W'(DEPTH - 1) |-> ptr == '0);
endmodule

bind fdiag_top fdiag_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .faulty     (faulty),
    .sa0        (sa0),
    .sa1        (sa1),
    .addr_valid (addr_valid),
    .any_fault  (any_fault),
    .ptr        (st_q.ptr)
);

// File: tb/tb_fdiag_top.sv
module tb_fdiag_top;
    localparam int            CLK_PERIOD = 10;
    localparam int            DEPTH      = 24;
    localparam logic [23:0]   PATTERN    = 24'h5A9C36;
    localparam int            ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              obs_bit = 1'b0;
    logic [ADDR_W-1:0] test_addr = '0;
    logic              faulty, sa0, sa1, addr_valid, any_fault;
    logic [ADDR_W-1:0] fault_addr;

    int errors = 0;
    int checks = 0;
    int idx    = 0;
    logic e_any = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdiag_top #(
        .DEPTH        (DEPTH),
        .EXP_BITS     (PATTERN),
        .ADDR_W       (ADDR_W),
        .TRISTATE_OUT (1'b0)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .obs_bit    (obs_bit),
        .test_addr  (test_addr),
        .faulty     (faulty),
        .sa0        (sa0),
        .sa1        (sa1),
        .fault_addr (fault_addr),
        .addr_valid (addr_valid),
        .any_fault  (any_fault)
    );

    function automatic logic exp_at(int k);
        return PATTERN[k % DEPTH];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 faulty", 32'(faulty), 0);
        chk("R6 sa0/sa1", 32'({sa0, sa1}), 0);
        chk("R6 any_fault", 32'(any_fault), 0);
        chk("R6 fault_addr", 32'(fault_addr), 0);
        rst = 1'b0;
        idx = 0;
        e_any = 1'b0;
    endtask

    // Drive one response bit, then check the registered result one clock on.
    task automatic step(logic o, logic [ADDR_W-1:0] a, string tag);
        logic e, ef, es0, es1;
        obs_bit = o;
        test_addr = a;
        e   = exp_at(idx);
        ef  = o ^ e;
        es0 = e & ~o;
        es1 = ~e & o;
        e_any = e_any | ef;
        @(negedge clk);
        chk({tag, " R2 faulty"}, 32'(faulty), 32'(ef));
        chk("R3 sa0", 32'(sa0), 32'(es0));
        chk("R3 sa1", 32'(sa1), 32'(es1));
        chk("R4 addr_valid", 32'(addr_valid), 32'(ef));
        chk("R4 fault_addr", 32'(fault_addr), ef ? 32'(a) : 0);
        chk("R5 any_fault", 32'(any_fault), 32'(e_any));
        idx = (idx == DEPTH - 1) ? 0 : idx + 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R1: entry 0 is first; mismatch on it, then match on entry 1.
        step(~exp_at(0), 4'hA, "R1 entry0");
        step(exp_at(1), 4'h3, "R1 entry1");
        // R5: matching cycles keep the sticky flag.
        for (int i = 0; i < 5; i++) step(exp_at(idx), 4'(i), "R5 hold");

        // R7: run past the end, then mismatch on entries after the wrap.
        while (idx != 0) step(exp_at(idx), 4'hF, "R7 run");
        step(~exp_at(0), 4'h8, "R7 wrap0");
        step(~exp_at(1), 4'hB, "R7 wrap1");
        step(exp_at(2), 4'h2, "R7 wrap2");

        // Back-to-back mismatches of both kinds give pulses each cycle.
        for (int i = 0; i < 6; i++) step(~exp_at(idx), 4'(i + 8), "R2 burst");

        // R6: reset mid-run restarts the sequence and clears the record.
        do_reset();
        step(exp_at(0), 4'h1, "R6 restart");
        step(~exp_at(1), 4'h7, "R6 restart1");

        // Random responses, mostly matching, over several wraps.
        for (int i = 0; i < 150; i++) begin
            logic flip;
            flip = ($urandom_range(0, 9) < 2);
            step(exp_at(idx) ^ flip, 4'($urandom_range(0, 15)), "rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule